// File: doc/BRIEF.md
# Unscaled-Offset Load/Store Decode Stage

This stage sits between instruction fetch and the memory pipeline of a 64-bit core. It takes one load/store instruction at a time: its size field, its two-bit operation field, a 9-bit signed byte offset, the base and target register indices, and the current values of the base register and the stack pointer. From the size/operation pair it works out the kind of memory operation. That is a store, a zero-extending load, a sign-extending load into a 32-bit or 64-bit register, or a prefetch. Certain pairs are trapped as undefined. The stage also forms the effective address by adding the unscaled, sign-extended offset to the base.

The decoded result is held in an output register under a valid/ready handshake. An undefined instruction never raises the valid output, so nothing reaches memory or the register file for it. The stage instead reports it through a one-cycle undefined flag. A combinational side path takes data returned by memory and widens it to the register width of the instruction currently held. It applies sign or zero extension as the decode chose.

Top module: `ldst_ofs_decode`

## Requirements
- R1: With operation bit 1 clear, operation bit 0 selects load (1) or store (0). The access is unsigned, and the register is 64 bits wide only for size 3, otherwise 32. The operation class output encodes store as 0, load as 1 and prefetch as 2.
- R2: With operation bit 1 set and size 3, the class is prefetch. If operation bit 0 is also set, the instruction is undefined.
- R3: With operation bit 1 set and size 0 to 2, the class is a signed load. The register is 32 bits when operation bit 0 is set and 64 bits when it is clear, and size 2 with operation bit 0 set is undefined. The signed flag is never set for a store or a prefetch.
- R4: The access width output equals 8 shifted left by size (8, 16, 32 or 64).
- R5: The address equals the base value plus the 9-bit offset sign-extended to 64 bits (range -256..255), wrapping modulo 2^64.
- R6: Base index 31 takes the stack pointer value in place of the base register value. The SP alignment-check output is high exactly when the index is 31 and the class is not prefetch.
- R7: The tag-check output is high exactly when the class is not prefetch and the base index is not 31.
- R8: The target output carries the 5-bit target field unchanged. For a prefetch this is the prefetch operation code.
- R9: The writeback data output holds the low 8<<size bits of the load data input, sign-extended when the signed flag is set and zero-extended otherwise. For a 32-bit register the upper 32 bits are zero.
- R10: An accepted undefined instruction leaves the valid output low and raises the undefined output for one transfer. An accepted defined instruction raises the valid output.
- R11: The input ready equals the downstream ready. While the downstream ready is low, no instruction is taken and all registered outputs keep their values.
- R12: After reset, the valid and undefined outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_ready | output | 1 | Stage takes the instruction this cycle |
| in_size | input | 2 | Size field |
| in_opc | input | 2 | Operation field |
| in_imm | input | 9 | Signed byte offset |
| in_base_idx | input | 5 | Base register index |
| in_tgt_idx | input | 5 | Target register field |
| in_base_val | input | 64 | Value of the indexed base register |
| in_sp_val | input | 64 | Stack pointer value |
| out_ready | input | 1 | Downstream can take a result |
| out_valid | output | 1 | Decoded, defined instruction held |
| out_undef | output | 1 | Accepted instruction was undefined |
| out_op | output | 2 | Class: 0 store, 1 load, 2 prefetch |
| out_acc_bits | output | 7 | Access width in bits |
| out_reg64 | output | 1 | Destination register is 64 bits |
| out_signed | output | 1 | Sign-extending load |
| out_addr | output | 64 | Effective address |
| out_tgt | output | 5 | Target register or prefetch code |
| out_sp_chk | output | 1 | Request SP alignment check |
| out_tag_chk | output | 1 | Access is tag-checked |
| ld_data | input | 64 | Data returned by memory |
| wb_data | output | 64 | Extended data for register writeback |

## Verification
Every cycle, the assertions check the following. An undefined result never coexists with a valid one. A prefetch never requests either check, and the tag check and the SP check are never both raised. The signed flag appears only on loads. Held outputs stay put while the downstream stalls, and an accepted defined instruction always yields a valid result. The bench's cycle model is needed for the values themselves. That covers the full size/operation table and the computed addresses, including wrap past zero at both ends. It also covers the stack-pointer substitution and the extension of returned data for each width and sign mode.

// File: rtl/ldst_dec_pkg.sv
package ldst_dec_pkg;

   typedef enum logic [1:0] {
      MOP_STORE    = 2'd0,
      MOP_LOAD     = 2'd1,
      MOP_PREFETCH = 2'd2
   } mem_op_e;

   typedef struct packed {
      mem_op_e op;
      logic    reg_wide;
      logic    sext;
      logic    undef;
   } op_decode_t;

endpackage

// File: rtl/ldst_op_decode.sv
module ldst_op_decode
   import ldst_dec_pkg::*;
#(
   parameter int SIZE_W = 2
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic [1:0]        opc_i,
   output op_decode_t        dec_o
);
   localparam logic [SIZE_W-1:0] SZ_MAX  = {SIZE_W{1'b1}};
   localparam logic [SIZE_W-1:0] SZ_WORD = SZ_MAX - SIZE_W'(1);

   generate
      if (SIZE_W != 2) begin : g_bad_size
         $error("ldst_op_decode: SIZE_W must be 2");
      end
   endgenerate

   always_comb begin
      dec_o = '{op: MOP_STORE, reg_wide: 1'b0, sext: 1'b0, undef: 1'b0};
      if (!opc_i[1]) begin
         dec_o.op       = opc_i[0] ? MOP_LOAD : MOP_STORE;
         dec_o.reg_wide = (size_i == SZ_MAX);
      end else if (size_i == SZ_MAX) begin
         dec_o.op    = MOP_PREFETCH;
         dec_o.undef = opc_i[0];
      end else begin
         dec_o.op       = MOP_LOAD;
         dec_o.sext     = 1'b1;
         dec_o.reg_wide = !opc_i[0];
         dec_o.undef    = (size_i == SZ_WORD) && opc_i[0];
      end
   end

endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen #(
   parameter int XLEN  = 64,
   parameter int IMM_W = 9,
   parameter int IDX_W = 5
) (
   input  logic [IDX_W-1:0] base_idx_i,
   input  logic [XLEN-1:0]  base_val_i,
   input  logic [XLEN-1:0]  sp_val_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic             use_sp_o,
   output logic [XLEN-1:0]  addr_o
);
   localparam logic [IDX_W-1:0] SP_IDX = {IDX_W{1'b1}};
   localparam int               PAD_W  = XLEN - IMM_W;

   generate
      if (IMM_W >= XLEN || IMM_W < 2) begin : g_bad_imm
         $error("ldst_addr_gen: IMM_W out of range");
      end
   endgenerate

   logic [XLEN-1:0] base_c;
   logic [XLEN-1:0] ofs_c;

   assign use_sp_o = (base_idx_i == SP_IDX);
   assign base_c   = use_sp_o ? sp_val_i : base_val_i;
   assign ofs_c    = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
   assign addr_o   = base_c + ofs_c;

endmodule

// File: rtl/ldst_load_extend.sv
module ldst_load_extend #(
   parameter int XLEN   = 64,
   parameter int SIZE_W = 2
) (
   input  logic [XLEN-1:0]   data_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              sext_i,
   input  logic              reg_wide_i,
   output logic [XLEN-1:0]   data_o
);
   localparam int NLANE = 1 << SIZE_W;
   localparam int HALF  = XLEN / 2;

   generate
      if ((8 << (NLANE - 1)) != XLEN) begin : g_bad_width
         $error("ldst_load_extend: widest access must equal XLEN");
      end
   endgenerate

   logic [XLEN-1:0] lane_c [NLANE];

   for (genvar s = 0; s < NLANE; s++) begin : g_lane
      localparam int LW = 8 << s;
      if (LW >= XLEN) begin : g_full
         assign lane_c[s] = data_i;
      end else begin : g_part
         assign lane_c[s] = {{(XLEN-LW){sext_i & data_i[LW-1]}}, data_i[LW-1:0]};
      end
   end

   logic [XLEN-1:0] sel_c;
   assign sel_c  = lane_c[size_i];
   assign data_o = reg_wide_i ? sel_c : {{(XLEN-HALF){1'b0}}, sel_c[HALF-1:0]};

endmodule

// File: rtl/ldst_ofs_decode.sv
module ldst_ofs_decode
   import ldst_dec_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int IMM_W  = 9,
   parameter int IDX_W  = 5,
   parameter int SIZE_W = 2,
   parameter int ACC_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [SIZE_W-1:0] in_size,
   input  logic [1:0]        in_opc,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic [IDX_W-1:0]  in_base_idx,
   input  logic [IDX_W-1:0]  in_tgt_idx,
   input  logic [XLEN-1:0]   in_base_val,
   input  logic [XLEN-1:0]   in_sp_val,
   input  logic              out_ready,
   output logic              out_valid,
   output logic              out_undef,
   output logic [1:0]        out_op,
   output logic [ACC_W-1:0]  out_acc_bits,
   output logic              out_reg64,
   output logic              out_signed,
   output logic [XLEN-1:0]   out_addr,
   output logic [IDX_W-1:0]  out_tgt,
   output logic              out_sp_chk,
   output logic              out_tag_chk,
   input  logic [XLEN-1:0]   ld_data,
   output logic [XLEN-1:0]   wb_data
);
   localparam int ACC_MIN = $clog2(XLEN) + 1;

   generate
      if (ACC_W < ACC_MIN) begin : g_bad_acc
         $error("ldst_ofs_decode: ACC_W too narrow for XLEN");
      end
   endgenerate

   // ---------------- decode and address ----------------
   op_decode_t      dec_c;
   logic            use_sp_c;
   logic [XLEN-1:0] addr_c;
   logic            is_pf_c;
   logic            take_c;

   ldst_op_decode #(.SIZE_W(SIZE_W)) u_op (
      .size_i (in_size),
      .opc_i  (in_opc),
      .dec_o  (dec_c)
   );

   ldst_addr_gen #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_addr (
      .base_idx_i (in_base_idx),
      .base_val_i (in_base_val),
      .sp_val_i   (in_sp_val),
      .imm_i      (in_imm),
      .use_sp_o   (use_sp_c),
      .addr_o     (addr_c)
   );

   assign is_pf_c  = (dec_c.op == MOP_PREFETCH);
   assign in_ready = out_ready;
   assign take_c   = in_valid && out_ready;

   // ---------------- output register ----------------
   logic [SIZE_W-1:0] size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_undef    <= 1'b0;
         out_op       <= 2'(MOP_STORE);
         out_acc_bits <= '0;
         out_reg64    <= 1'b0;
         out_signed   <= 1'b0;
         out_addr     <= '0;
         out_tgt      <= '0;
         out_sp_chk   <= 1'b0;
         out_tag_chk  <= 1'b0;
         size_q       <= '0;
      end else if (out_ready) begin
         out_valid <= in_valid && !dec_c.undef;
         out_undef <= in_valid && dec_c.undef;
         if (take_c) begin
            out_op       <= 2'(dec_c.op);
            out_acc_bits <= ACC_W'(32'd8 << in_size);
            out_reg64    <= dec_c.reg_wide;
            out_signed   <= dec_c.sext;
            out_addr     <= addr_c;
            out_tgt      <= in_tgt_idx;
            out_sp_chk   <= use_sp_c && !is_pf_c;
            out_tag_chk  <= !use_sp_c && !is_pf_c;
            size_q       <= in_size;
         end
      end
   end

   // ---------------- load data extension ----------------
   ldst_load_extend #(.XLEN(XLEN), .SIZE_W(SIZE_W)) u_ext (
      .data_i     (ld_data),
      .size_i     (size_q),
      .sext_i     (out_signed),
      .reg_wide_i (out_reg64),
      .data_o     (wb_data)
   );

   // ---------------- assertions ----------------
   logic armed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   AST_UNDEF_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> !out_valid);  // R10

   AST_DEFINED_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_c && !dec_c.undef) |=> out_valid);  // R10

   AST_PREFETCH_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == 2'(MOP_PREFETCH)) |-> (!out_sp_chk && !out_tag_chk));  // R6

   AST_CHECK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_sp_chk && out_tag_chk));  // R7

   AST_SIGNED_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_signed) |-> (out_op == 2'(MOP_LOAD)));  // R3

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
      !out_ready |=> ($stable(out_valid) && $stable(out_undef) && $stable(out_addr)
                      && $stable(out_op) && $stable(out_tgt)));  // R11

endmodule

// File: tb/ldst_ofs_decode_bench.sv
module ldst_ofs_decode_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_size = '0;
   logic [1:0]  in_opc = '0;
   logic [8:0]  in_imm = '0;
   logic [4:0]  in_base_idx = '0;
   logic [4:0]  in_tgt_idx = '0;
   logic [63:0] in_base_val = '0;
   logic [63:0] in_sp_val = '0;
   logic        out_ready = 1'b0;
   logic        out_valid, out_undef, out_reg64, out_signed, out_sp_chk, out_tag_chk;
   logic [1:0]  out_op;
   logic [6:0]  out_acc_bits;
   logic [63:0] out_addr, ld_data, wb_data;
   logic [4:0]  out_tgt;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   ldst_ofs_decode u_ldst_ofs_decode (
      .clk, .rst_n, .in_valid, .in_ready, .in_size, .in_opc, .in_imm,
      .in_base_idx, .in_tgt_idx, .in_base_val, .in_sp_val, .out_ready,
      .out_valid, .out_undef, .out_op, .out_acc_bits, .out_reg64, .out_signed,
      .out_addr, .out_tgt, .out_sp_chk, .out_tag_chk, .ld_data, .wb_data
   );

   initial ld_data = '0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          e_valid, e_undef, e_reg64, e_signed, e_sp, e_tag;
   int          e_op, e_bits;
   logic [63:0] e_addr;
   logic [4:0]  e_tgt;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 0; e_undef = 0;
      end else if (out_ready) begin
         if (in_valid) begin
            bit u;
            u = 0; e_signed = 0; e_reg64 = 0;
            if (in_opc[1] == 1'b0) begin
               e_op = in_opc[0] ? 1 : 0;
               e_reg64 = (in_size == 2'd3);
            end else if (in_size == 2'd3) begin
               e_op = 2;
               u = in_opc[0];
            end else begin
               e_op = 1; e_signed = 1;
               e_reg64 = !in_opc[0];
               u = (in_size == 2'd2) && in_opc[0];
            end
            e_bits  = 8 * (2 ** in_size);
            e_addr  = ((in_base_idx == 5'd31) ? in_sp_val : in_base_val)
                      + 64'($signed(in_imm));
            e_sp    = (in_base_idx == 5'd31) && (e_op != 2);
            e_tag   = (in_base_idx != 5'd31) && (e_op != 2);
            e_tgt   = in_tgt_idx;
            e_valid = !u;
            e_undef = u;
         end else begin
            e_valid = 0; e_undef = 0;
         end
      end
   end

   function automatic logic [63:0] exp_wb(input logic [63:0] d);
      logic [63:0] r;
      r = '0;
      for (int b = 0; b < 64; b++) begin
         if (b < e_bits) r[b] = d[b];
         else            r[b] = e_signed ? d[e_bits-1] : 1'b0;
      end
      if (!e_reg64) r[63:32] = '0;
      return r;
   endfunction

   task automatic compare();
      chk(in_ready == out_ready, "R11 in_ready", 64'(in_ready), 64'(out_ready));
      chk(out_valid == e_valid, "R10 valid", 64'(out_valid), 64'(e_valid));
      chk(out_undef == e_undef, "R10 undef", 64'(out_undef), 64'(e_undef));
      if (e_valid) begin
         chk(out_op == 2'(e_op), "R1 op", 64'(out_op), 64'(e_op));
         chk(out_acc_bits == 7'(e_bits), "R4 width", 64'(out_acc_bits), 64'(e_bits));
         if (e_op == 1) begin
            chk(out_reg64 == e_reg64, "R1/R3 reg64", 64'(out_reg64), 64'(e_reg64));
            chk(out_signed == e_signed, "R3 signed", 64'(out_signed), 64'(e_signed));
            chk(wb_data == exp_wb(ld_data), "R9 wb_data", wb_data, exp_wb(ld_data));
         end else begin
            chk(out_signed == 1'b0, "R2 signed", 64'(out_signed), 64'd0);
         end
         chk(out_addr == e_addr, "R5 addr", out_addr, e_addr);
         chk(out_sp_chk == e_sp, "R6 sp_chk", 64'(out_sp_chk), 64'(e_sp));
         chk(out_tag_chk == e_tag, "R7 tag_chk", 64'(out_tag_chk), 64'(e_tag));
         chk(out_tgt == e_tgt, "R8 tgt", 64'(out_tgt), 64'(e_tgt));
      end
   endtask

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R12 reset valid", 64'(out_valid), 64'd0);
      chk(out_undef == 1'b0, "R12 reset undef", 64'(out_undef), 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         compare();
         ld_data     = {$urandom, $urandom};
         in_base_val = {$urandom, $urandom};
         in_sp_val   = {$urandom, $urandom};
         in_tgt_idx  = 5'($urandom);
         in_imm      = 9'($urandom);
         in_base_idx = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 31);
         if (i < 32) begin
            // sweep every size/operation pair, with and without SP base
            in_valid  = 1'b1;
            out_ready = 1'b1;
            {in_opc, in_size} = 4'(i);
            in_base_idx = (i >= 16) ? 5'd31 : 5'd3;
         end else if (i < 36) begin
            // R5 wrap at both ends of the address space
            in_valid = 1'b1; out_ready = 1'b1;
            in_opc = 2'b01; in_size = 2'd0; in_base_idx = 5'd7;
            in_base_val = (i % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFF0 : 64'h0000_0000_0000_0010;
            in_imm = (i % 2 == 0) ? 9'd255 : 9'h100;
         end else begin
            in_valid  = ($urandom % 4) != 0;
            out_ready = ($urandom % 4) != 0;
            in_opc    = 2'($urandom);
            in_size   = 2'($urandom);
         end
      end
      @(negedge clk);
      compare();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule